// File: doc/BRIEF.md
# Serial DAC Input Latch Interface

This block is the digital front end of a 12-bit serial-input digital-to-analog converter. A host drives a three-wire stream: a serial clock, a data line and an active-low select. While select is low, each rising serial clock edge pushes one data bit into a shift register, most significant bit first. When select returns high, the assembled word is copied into a holding register, and that register drives the parallel converter code.

All three serial pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected on the synchronised copies. The commit is tied to the release of select, not to a bit count. A frame of any length therefore commits whatever the shift register holds at that moment. A single-cycle update strobe marks every commit that changes the held code.

Top module: `dac_serial_latch`

## Requirements
- R1: After reset, `code_o` is 0 (the ground-level code) and `update_o` is 0.
- R2: During a frame of exactly 12 serial clocks, the first bit shifted in lands in `code_o[11]` and the last in `code_o[0]`. The code is straight binary: 12'hFFF is full scale minus one LSB, and 12'h000 is ground.
- R3: While `cs_ni` is high, serial clock edges do not alter the shift register. An empty frame sent afterwards commits the unchanged word.
- R4: `code_o` changes only at the release of select. It takes its new value two system clocks after the first system clock edge that samples `cs_ni` high. It holds steady for the whole of a frame.
- R5: When a frame carries more than 12 serial clocks, only the last 12 bits received are committed.
- R6: When a frame carries k < 12 serial clocks, the committed word is the previous shift register contents moved up by k places, with the k new bits in the low positions.
- R7: `update_o` is high for exactly one system clock, in the cycle right after a commit that changes `code_o`. It stays low after a commit that loads an unchanged code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from the host (asynchronous) |
| sdi_i | input | 1 | Serial data from the host (asynchronous) |
| cs_ni | input | 1 | Active-low frame select from the host (asynchronous) |
| code_o | output | 12 | Held converter code |
| update_o | output | 1 | One-cycle pulse after the held code changes |

## Verification
The assertions assume that each serial pin holds every level for at least two system clocks, so that no edge is lost in the synchronisers. They also assume that the data line is stable around each rising serial clock, so that it passes through its synchroniser alongside the clock. The stimulus keeps every serial clock phase four system clocks long, changes data only while the serial clock is low, and allows four system clocks of settling on each side of every select transition. Long frames, short frames, empty frames, repeated codes and serial clock activity while deselected are each placed between these safe transitions.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  localparam int unsigned NUM_PINS = 3;
  localparam int unsigned IDX_SCLK = 0;
  localparam int unsigned IDX_SDI  = 1;
  localparam int unsigned IDX_CSN  = 2;
  // idle levels: clock low, data low, select released
  localparam logic [NUM_PINS-1:0] PIN_IDLE = 3'b100;
endpackage

// File: rtl/dsl_sync_edge.sv
module dsl_sync_edge #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o
);
  initial begin
    a_stages_min: assert (STAGES >= 2);
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RESET_VAL[b]}};
        last_q  <= RESET_VAL[b];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[b]};
        last_q  <= chain_q[STAGES-1];
      end
    end

    assign level_o[b] = chain_q[STAGES-1];
    assign rise_o[b]  = chain_q[STAGES-1] & ~last_q;

    // R4: an edge is reported for one cycle only
    a_r4_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/dsl_shift_reg.sv
module dsl_shift_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_o <= '0;
    else if (shift_en_i) word_o <= {word_o[WIDTH-2:0], bit_i};
  end

  // R2: new bit enters at the bottom, older bits move toward the top
  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (word_o[0] == $past(bit_i)) &&
                   (word_o[WIDTH-1:1] == $past(word_o[WIDTH-2:0])));
endmodule

// File: rtl/dsl_hold_reg.sv
module dsl_hold_reg #(
  parameter int unsigned WIDTH = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] code_o,
  output logic             update_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o   <= '0;
      update_o <= 1'b0;
    end else begin
      update_o <= load_i && (word_i != code_o);
      if (load_i) code_o <= word_i;
    end
  end

  a_r4_code_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_o));

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  a_r7_pulse_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> code_o != $past(code_o));
endmodule

// File: rtl/dac_serial_latch.sv
module dac_serial_latch #(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              cs_ni,
  output logic [CODE_W-1:0] code_o,
  output logic              update_o
);
  import dsl_pkg::*;

  logic [NUM_PINS-1:0] pins_raw;
  logic [NUM_PINS-1:0] pins_lvl;
  logic [NUM_PINS-1:0] pins_rise;
  logic                shift_en;
  logic                commit;
  logic [CODE_W-1:0]   shift_word;

  always_comb begin
    pins_raw           = '0;
    pins_raw[IDX_SCLK] = sclk_i;
    pins_raw[IDX_SDI]  = sdi_i;
    pins_raw[IDX_CSN]  = cs_ni;
  end

  dsl_sync_edge #(
    .WIDTH    (NUM_PINS),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(PIN_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pins_raw),
    .level_o(pins_lvl),
    .rise_o (pins_rise)
  );

  assign shift_en = pins_rise[IDX_SCLK] & ~pins_lvl[IDX_CSN];
  // release of select commits, regardless of bit count
  assign commit   = pins_rise[IDX_CSN];

  dsl_shift_reg #(.WIDTH(CODE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .bit_i     (pins_lvl[IDX_SDI]),
    .word_o    (shift_word)
  );

  dsl_hold_reg #(.WIDTH(CODE_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (commit),
    .word_i  (shift_word),
    .code_o  (code_o),
    .update_o(update_o)
  );

  a_r3_idle_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_lvl[IDX_CSN] |=> $stable(shift_word));

  a_r4_commit_only_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pins_lvl[IDX_CSN] |=> $stable(code_o));
endmodule

// File: tb/sim_dac_serial_latch.sv
`timescale 1ns/1ps
module sim_dac_serial_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        cs_n = 1'b1;
  logic [11:0] code;
  logic        upd;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit mon_on   = 1'b0;

  // behavioural expectations
  int exp_sr   = 0;
  int exp_hold = 0;
  bit exp_upd  = 1'b0;

  always #5 clk = ~clk;

  dac_serial_latch u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_ni(cs_n),
    .code_o(code), .update_o(upd)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      check("R4 code_o", int'(code), exp_hold);
      check("R7 update_o", int'(upd), int'(exp_upd));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sclk_pulse(input bit b, input bit selected);
    sdi  = b;
    sclk = 1'b0;
    idle(4);
    sclk = 1'b1;
    if (selected) exp_sr = ((exp_sr << 1) | int'(b)) & 12'hFFF;
    idle(4);
    sclk = 1'b0;
  endtask

  // frame of n bits, first bit sent is bits[n-1]
  task automatic send_frame(input string tag, input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    idle(4);
    for (int i = n - 1; i >= 0; i--) sclk_pulse(bits[i], 1'b1);
    idle(4);
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_upd  = (exp_sr != exp_hold);
    exp_hold = exp_sr;
    @(negedge clk);
    check(tag, int'(code), exp_hold);
    @(posedge clk);
    #1;
    exp_upd = 1'b0;
    idle(4);
  endtask

  initial begin
    idle(3);
    check("R1 code after reset", int'(code), 0);
    check("R1 update after reset", int'(upd), 0);
    rst_n = 1'b1;
    idle(2);
    mon_on = 1'b1;

    send_frame("R2 12-bit frame A5C", 32'hA5C, 12);
    check("R2 value A5C", int'(code), 'hA5C);
    send_frame("R7 repeated code, no strobe", 32'hA5C, 12);
    send_frame("R2 full scale FFF", 32'hFFF, 12);
    send_frame("R5 16-bit frame keeps last 12", 32'hBEEF, 16);
    check("R5 value EEF", int'(code), 'hEEF);
    send_frame("R6 5-bit frame", 32'h16, 5);
    check("R6 value", int'(code), ((32'hEEF << 5) | 32'h16) & 32'hFFF);
    // clocks while deselected must not shift
    for (int i = 0; i < 10; i++) sclk_pulse(i[0], 1'b0);
    send_frame("R3 empty frame after deselected clocks", 32'h0, 0);
    check("R3 value unchanged", int'(code), ((32'hEEF << 5) | 32'h16) & 32'hFFF);
    send_frame("R2 ground code 000", 32'h000, 12);
    send_frame("R2 pattern 801", 32'h801, 12);
    check("R2 MSB at bit 11", int'(code[11]), 1);
    check("R2 LSB at bit 0", int'(code[0]), 1);

    mon_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule